// File: doc/BRIEF.md
# DMA Completion Interrupt Router

This block collects the completion interrupt levels of a set of DMA channels and presents them in two views. The first view is a DMA-side status word with one bit per channel. The second view is the interrupt controller side. There, the channels map onto interrupt lines, and those lines land in a 32-bit pending word. An enable word masks the pending word. A basic pending word then summarises the whole bank in a single bit.

The low-numbered channels each own a dedicated line. All remaining channels are OR-ed together onto one shared line, which sits just above the dedicated ones. Software programs the enable word through a small register port. Writing ones to the set offset turns enable bits on, and writing ones to the clear offset turns them off. The same port reads back all four views. A single CPU interrupt output is raised whenever the basic pending word is non-zero.

Pending bits are not latched. They follow the registered channel levels through the enable mask, so a pending bit drops as soon as its source drops or its enable is cleared.

Top module: `dma_irq_router`

## Requirements
- R1: The status output and the status register (offset 0xFE0) show bit n equal to the level of channel n. Each bit follows its channel input one clock after that input is sampled.
- R2: Each channel n below the dedicated count (channels 0 to 10) drives line n. Line k appears as bit 16+k of the pending word (offset 0x04) whenever enable bit 16+k is set.
- R3: Channels 11 to 14 are OR-ed onto line 11 (pending bit 27). Any one of them, or any combination of them, sets that single bit.
- R4: Writing the enable-set register (offset 0x10) sets every enable bit written as 1. Bits written as 0 keep their value.
- R5: Writing the enable-clear register (offset 0x1C) clears every enable bit written as 1. Bits written as 0 keep their value.
- R6: A pending bit is the unlatched AND of its line and its enable bit. It clears as soon as its source drops or its enable is cleared.
- R7: Bit 8 of the basic pending word (offset 0x00) is set exactly when any pending bit is set. All other basic bits read 0.
- R8: The CPU interrupt output is high exactly when the basic pending word is non-zero.
- R9: After reset, the status, pending, basic and enable words are all 0, and so is the read data.
- R10: A read returns its data on the read-data port one clock after the request. Reading offset 0x10 or 0x1C returns the enable word. Any unmapped offset reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| chan_irq | input | 15 | Per-channel completion interrupt levels |
| req_valid | input | 1 | Register access request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Register byte offset |
| req_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid one clock after a read request |
| irq_status | output | 15 | DMA-side per-channel status word |
| gpu_pend | output | 32 | Enabled pending word for the DMA lines |
| basic_pend | output | 32 | Basic pending word carrying the summary bit |
| cpu_irq | output | 1 | Interrupt request towards the CPU |

## Verification
The bench builds the router with its default parameters: 15 channels, 11 dedicated lines, line base 16 and summary bit 8. These values put the last dedicated channel (10) and both ends of the shared group (11 and 14) inside the stimulus table. The last dedicated line (bit 26) and the shared line (bit 27) therefore both get exercised. The enable mask is varied per vector, so masked sources, partial enables and the summary bit can be observed together.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;

    localparam int ADDR_W = 12;

    localparam logic [ADDR_W-1:0] OFS_BASIC  = 12'h000;
    localparam logic [ADDR_W-1:0] OFS_PEND   = 12'h004;
    localparam logic [ADDR_W-1:0] OFS_EN_SET = 12'h010;
    localparam logic [ADDR_W-1:0] OFS_EN_CLR = 12'h01C;
    localparam logic [ADDR_W-1:0] OFS_STATUS = 12'hFE0;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_BASIC,
        SEL_PEND,
        SEL_EN_SET,
        SEL_EN_CLR,
        SEL_STATUS
    } reg_sel_e;

    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        case (a)
            OFS_BASIC:  return SEL_BASIC;
            OFS_PEND:   return SEL_PEND;
            OFS_EN_SET: return SEL_EN_SET;
            OFS_EN_CLR: return SEL_EN_CLR;
            OFS_STATUS: return SEL_STATUS;
            default:    return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/dma_irq_linemap.sv
module dma_irq_linemap #(
    parameter int NUM_CH    = 15,
    parameter int NUM_DED   = 11,
    parameter int NUM_LINES = 12
) (
    input  logic [NUM_CH-1:0]    chan,
    output logic [NUM_LINES-1:0] lines
);

    // Dedicated lines: one channel each.
    for (genvar i = 0; i < NUM_DED; i++) begin : g_ded
        assign lines[i] = chan[i];
    end

    // Shared line: OR of every channel above the dedicated range.
    if (NUM_CH > NUM_DED) begin : g_shared
        assign lines[NUM_DED] = |chan[NUM_CH-1:NUM_DED];
    end else begin : g_no_shared
        assign lines[NUM_DED] = 1'b0;
    end

endmodule

// File: rtl/dma_irq_bank.sv
module dma_irq_bank #(
    parameter int DATA_W      = 32,
    parameter int NUM_LINES   = 12,
    parameter int LINE_BASE   = 16,
    parameter int SUMMARY_BIT = 8
) (
    input  logic [NUM_LINES-1:0] lines,
    input  logic [DATA_W-1:0]    enable,
    output logic [DATA_W-1:0]    pend,
    output logic [DATA_W-1:0]    basic
);

    logic [DATA_W-1:0] raw;

    // Place each line at its bit position in the pending word.
    for (genvar k = 0; k < DATA_W; k++) begin : g_bit
        if (k >= LINE_BASE && k < LINE_BASE + NUM_LINES) begin : g_line
            assign raw[k] = lines[k-LINE_BASE];
        end else begin : g_zero
            assign raw[k] = 1'b0;
        end
    end

    always_comb begin
        pend               = raw & enable;
        basic              = '0;
        basic[SUMMARY_BIT] = |pend;
    end

endmodule

// File: rtl/dma_irq_regs.sv
module dma_irq_regs
    import dma_irq_pkg::*;
#(
    parameter int NUM_CH = 15,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] chan_irq,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] pend,
    input  logic [DATA_W-1:0] basic,
    output logic [NUM_CH-1:0] chan_q,
    output logic [DATA_W-1:0] en_q,
    output logic [DATA_W-1:0] rdata_q
);

    typedef struct packed {
        logic [NUM_CH-1:0] chan;
        logic [DATA_W-1:0] en;
        logic [DATA_W-1:0] rdata;
    } state_t;

    state_t   st_d, st_q;
    reg_sel_e sel;
    logic     armed_q;

    always_comb begin
        st_d      = st_q;
        sel       = decode_addr(req_addr);
        st_d.chan = chan_irq;
        if (req_valid && req_write) begin
            if (sel == SEL_EN_SET) st_d.en = st_q.en | req_wdata;
            if (sel == SEL_EN_CLR) st_d.en = st_q.en & ~req_wdata;
        end
        if (req_valid && !req_write) begin
            case (sel)
                SEL_BASIC:  st_d.rdata = basic;
                SEL_PEND:   st_d.rdata = pend;
                SEL_EN_SET,
                SEL_EN_CLR: st_d.rdata = st_q.en;
                SEL_STATUS: st_d.rdata = {{(DATA_W-NUM_CH){1'b0}}, st_q.chan};
                default:    st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= '0;
            armed_q <= 1'b0;
        end else begin
            st_q    <= st_d;
            armed_q <= 1'b1;
        end
    end

    assign chan_q  = st_q.chan;
    assign en_q    = st_q.en;
    assign rdata_q = st_q.rdata;

    // R1: status follows the channel input one clock later
    a_r1_status_follows: assert property (@(posedge clk) disable iff (rst)
        armed_q |-> chan_q == $past(chan_irq));

    // R4: written ones become set in the enable word
    a_r4_enable_sets: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && req_addr == OFS_EN_SET)
        |=> (en_q & $past(req_wdata)) == $past(req_wdata));

    // R5: written ones become clear in the enable word
    a_r5_disable_clears: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && req_addr == OFS_EN_CLR)
        |=> (en_q & $past(req_wdata)) == '0);

    // R4/R5: enable word holds without an enable write
    a_r4_enable_holds: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && req_write && (req_addr == OFS_EN_SET || req_addr == OFS_EN_CLR))
        |=> $stable(en_q));

    // R10: unmapped reads return zero
    a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write && decode_addr(req_addr) == SEL_NONE)
        |=> rdata_q == '0);

endmodule

// File: rtl/dma_irq_router.sv
module dma_irq_router
    import dma_irq_pkg::*;
#(
    parameter int NUM_CH      = 15,
    parameter int NUM_DED     = 11,
    parameter int DATA_W      = 32,
    parameter int LINE_BASE   = 16,
    parameter int SUMMARY_BIT = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] chan_irq,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [11:0]       req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rd_data,
    output logic [NUM_CH-1:0] irq_status,
    output logic [DATA_W-1:0] gpu_pend,
    output logic [DATA_W-1:0] basic_pend,
    output logic              cpu_irq
);

    localparam int NUM_LINES = NUM_DED + 1;
    localparam int SHARED_BIT = LINE_BASE + NUM_DED;

    logic [NUM_CH-1:0]    chan_q;
    logic [DATA_W-1:0]    en_q;
    logic [NUM_LINES-1:0] lines;

    dma_irq_regs #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .chan_irq  (chan_irq),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .pend      (gpu_pend),
        .basic     (basic_pend),
        .chan_q    (chan_q),
        .en_q      (en_q),
        .rdata_q   (rd_data)
    );

    dma_irq_linemap #(.NUM_CH(NUM_CH), .NUM_DED(NUM_DED), .NUM_LINES(NUM_LINES)) u_map (
        .chan  (chan_q),
        .lines (lines)
    );

    dma_irq_bank #(
        .DATA_W(DATA_W), .NUM_LINES(NUM_LINES),
        .LINE_BASE(LINE_BASE), .SUMMARY_BIT(SUMMARY_BIT)
    ) u_bank (
        .lines  (lines),
        .enable (en_q),
        .pend   (gpu_pend),
        .basic  (basic_pend)
    );

    assign irq_status = chan_q;
    assign cpu_irq    = |basic_pend;

    // R3: the shared pending bit reflects the upper channels through its enable
    a_r3_shared_line: assert property (@(posedge clk) disable iff (rst)
        gpu_pend[SHARED_BIT] == ((|irq_status[NUM_CH-1:NUM_DED]) && en_q[SHARED_BIT]));

    // R2: a dedicated channel shows at its pending bit when enabled
    a_r2_first_line: assert property (@(posedge clk) disable iff (rst)
        gpu_pend[LINE_BASE] == (irq_status[0] && en_q[LINE_BASE]));

    // R6: no pending bit without its enable
    a_r6_masked: assert property (@(posedge clk) disable iff (rst)
        (gpu_pend & ~en_q) == '0);

    // R7: summary bit tracks any pending bit
    a_r7_summary: assert property (@(posedge clk) disable iff (rst)
        basic_pend[SUMMARY_BIT] == (gpu_pend != '0));

    // R8: CPU request follows the basic word
    a_r8_cpu_irq: assert property (@(posedge clk) disable iff (rst)
        cpu_irq == (basic_pend != '0));

endmodule

// File: tb/dma_irq_router_test.sv
module dma_irq_router_test;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [14:0] chan_irq = '0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [11:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] rd_data, gpu_pend, basic_pend;
    logic [14:0] irq_status;
    logic        cpu_irq;

    int checks = 0;
    int errors = 0;

    // {channels, enable mask, expected pending word}
    localparam logic [78:0] VEC [NV] = '{
        {15'h0001, 32'hFFFF_FFFF, 32'h0001_0000},
        {15'h0400, 32'hFFFF_FFFF, 32'h0400_0000},
        {15'h0800, 32'hFFFF_FFFF, 32'h0800_0000},
        {15'h4000, 32'hFFFF_FFFF, 32'h0800_0000},
        {15'h7800, 32'hFFFF_FFFF, 32'h0800_0000},
        {15'h7FFF, 32'hFFFF_FFFF, 32'h0FFF_0000},
        {15'h0005, 32'h0001_0000, 32'h0001_0000},
        {15'h0004, 32'h0001_0000, 32'h0000_0000},
        {15'h1000, 32'h0800_0000, 32'h0800_0000},
        {15'h0000, 32'hFFFF_FFFF, 32'h0000_0000}
    };

    dma_irq_router uut (
        .clk(clk), .rst(rst), .chan_irq(chan_irq),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .rd_data(rd_data), .irq_status(irq_status),
        .gpu_pend(gpu_pend), .basic_pend(basic_pend), .cpu_irq(cpu_irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        d = rd_data;
    endtask

    task automatic set_chan(input logic [14:0] c);
        @(negedge clk);
        chan_irq = c;
        @(negedge clk);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R9: reset state
        chk("R9 status", {17'b0, irq_status}, 32'h0);
        chk("R9 pending", gpu_pend, 32'h0);
        chk("R9 basic", basic_pend, 32'h0);
        chk("R9 cpu_irq", {31'b0, cpu_irq}, 32'h0);
        chk("R9 rd_data", rd_data, 32'h0);
        rd(12'h010, r); chk("R9 enable", r, 32'h0);

        // Table: R1 R2 R3 R6 R7 R8 across vectors
        for (int i = 0; i < NV; i++) begin
            logic [14:0] c;
            logic [31:0] m, ep, eb;
            {c, m, ep} = VEC[i];
            eb = (ep != 0) ? 32'h0000_0100 : 32'h0;
            wr(12'h01C, 32'hFFFF_FFFF);
            wr(12'h010, m);
            set_chan(c);
            chk("R1 status port", {17'b0, irq_status}, {17'b0, c});
            chk("R2/R3/R6 pending", gpu_pend, ep);
            chk("R7 basic", basic_pend, eb);
            chk("R8 cpu_irq", {31'b0, cpu_irq}, {31'b0, eb != 0});
            rd(12'hFE0, r); chk("R1 status reg", r, {17'b0, c});
            rd(12'h004, r); chk("R10 pending reg", r, ep);
            rd(12'h000, r); chk("R10 basic reg", r, eb);
        end

        // R4: set bits accumulate; zeros have no effect
        wr(12'h01C, 32'hFFFF_FFFF);
        wr(12'h010, 32'h0001_0000);
        wr(12'h010, 32'h0002_0000);
        rd(12'h010, r); chk("R4 accumulate", r, 32'h0003_0000);
        wr(12'h010, 32'h0);
        rd(12'h010, r); chk("R4 zero write", r, 32'h0003_0000);

        // R5: clear one bit, zero write no effect, read via clear offset
        wr(12'h01C, 32'h0);
        rd(12'h01C, r); chk("R5 zero write", r, 32'h0003_0000);
        wr(12'h01C, 32'h0001_0000);
        rd(12'h01C, r); chk("R5 clear bit", r, 32'h0002_0000);

        // R6: disable while source high drops pending, no latching on drop
        wr(12'h010, 32'h0001_0000);
        set_chan(15'h0003);
        chk("R6 both set", gpu_pend, 32'h0003_0000);
        wr(12'h01C, 32'h0002_0000);
        chk("R6 disable drops", gpu_pend, 32'h0001_0000);
        set_chan(15'h0000);
        chk("R6 source drop", gpu_pend, 32'h0);
        chk("R8 cpu low", {31'b0, cpu_irq}, 32'h0);

        // R3: shared line masked when its enable is off
        wr(12'h01C, 32'hFFFF_FFFF);
        wr(12'h010, 32'h0400_0000);
        set_chan(15'h2000);
        chk("R3 shared masked", gpu_pend, 32'h0);
        wr(12'h010, 32'h0800_0000);
        chk("R3 shared enabled", gpu_pend, 32'h0800_0000);

        // R10: unmapped offset reads zero
        rd(12'h008, r); chk("R10 unmapped", r, 32'h0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule